// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor and decides whether an incoming group of cooperating threads can move in as a resident block. It keeps three running totals: resident blocks, resident threads and allocated shared-memory bytes. A request is taken only if all three totals stay at or below their limits once the request is added. Each request carries an identifier, a thread count and a shared-memory byte count, and arrives on a valid/ready handshake. A block is taken whole or not at all. After a block is taken, the controller reports how many 32-thread warps it occupies.

A legal request that does not fit yet waits with ready low until releases free enough room. A request that can never be legal is consumed at once and flagged with an error pulse. When a resident block finishes, its identifier arrives on the release port. Its threads, its shared memory and its slot then go back to the totals together. A release for an identifier that is not resident is flagged and has no other effect. A slot table holds each resident block's identifier and footprint, so the right amounts can be returned on release.

Top module: `block_admission_unit`

## Requirements
- R1: No more than MAX_BLOCKS (default 8) blocks are resident at once. A legal request that would need a ninth slot waits with reqReady low, even when threads and shared memory still have room.
- R2: The sum of resident thread counts never exceeds MAX_THREADS (default 768). A request that would push the sum past this waits, and a request that lands exactly on it is taken.
- R3: The sum of shared-memory bytes of resident blocks never exceeds SMEM_BYTES (default 16384). A request that lands exactly on it is taken, and one that would exceed it waits.
- R4: A request is illegal if any of these holds: its thread count is 0, its thread count is above MAX_BLOCK_THREADS (512), its byte count is above SMEM_BYTES, or its identifier is already resident. An illegal request gets reqReady high in the same cycle. reqError pulses for one cycle on the next cycle, admitValid stays low, and no total changes.
- R5: When a legal request is taken (reqValid and reqReady high at a rising edge), all three totals grow by its full amounts at that edge, and admitValid pulses high for the following cycle.
- R6: With each admitValid pulse, admitWarps equals the block's thread count divided by 32, rounded up.
- R7: A legal request that does not fit keeps reqReady low and leaves the totals unchanged for as long as it is held. It is taken in the first cycle in which the totals leave room.
- R8: A release whose identifier is resident returns that block's threads, its bytes and one slot at the same edge. relError stays low.
- R9: When a request is taken and a release is made in the same cycle, each total ends at old + request - released. Whether the request fits is judged on the totals from before that cycle's release.
- R10: A release whose identifier is not resident leaves the totals unchanged, and relError pulses for one cycle on the next cycle.
- R11: During and after reset, all three totals are zero, admitValid, reqError and relError are low, and reqReady is low while reqValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Admission request present |
| reqReady | output | 1 | Request taken or dropped this cycle |
| reqId | input | ID_W | Identifier of the requesting block |
| reqThreads | input | clog2(MAX_BLOCK_THREADS+1) | Thread count of the request |
| reqSmem | input | clog2(SMEM_BYTES+1) | Shared-memory bytes requested |
| admitValid | output | 1 | One-cycle pulse after a block is taken |
| admitWarps | output | clog2(MAX_BLOCK_THREADS/WARP_SIZE+1) | Warps of the block just taken |
| reqError | output | 1 | One-cycle pulse after an illegal request was dropped |
| relValid | input | 1 | Release strobe |
| relId | input | ID_W | Identifier of the block being released |
| relError | output | 1 | One-cycle pulse after a release for a non-resident identifier |
| residentBlocks | output | clog2(MAX_BLOCKS+1) | Count of resident blocks |
| residentThreads | output | clog2(MAX_THREADS+1) | Sum of resident thread counts |
| smemUsed | output | clog2(SMEM_BYTES+1) | Sum of resident shared-memory bytes |

## Verification
The hardest situation to reach is a request held waiting and then taken in the very cycle a release first makes room for it. A second hard case is a take and a release landing on the same edge. Both need the request to be held across several cycles while another input acts on its own schedule. The stimulus first fills the unit to its thread limit and holds a request over it. It checks that ready stays low, then fires one release and checks that ready rises in the next cycle. It also drives a request and a release in the same cycle, with totals chosen so that the result shows whether the release amounts and the request amounts were both applied. The block-slot limit is reached with small 64-thread blocks, so that only that one limit is binding.

// File: rtl/admit_pkg.sv
package admit_pkg;

  // Strobes the control issues to the datapath each cycle.
  typedef struct packed {
    logic take;   // legal request accepted, load a slot
    logic drop;   // illegal request consumed
    logic free;   // release hit a resident slot
    logic miss;   // release named a non-resident block
  } admit_strobe_t;

endpackage

// File: rtl/admit_datapath.sv
module admit_datapath
  import admit_pkg::*;
#(
  parameter int MAX_BLOCKS        = 8,
  parameter int MAX_THREADS       = 768,
  parameter int SMEM_BYTES        = 16384,
  parameter int MAX_BLOCK_THREADS = 512,
  parameter int WARP_SIZE         = 32,
  parameter int ID_W              = 8,
  localparam int RT_W  = $clog2(MAX_BLOCK_THREADS + 1),
  localparam int SM_W  = $clog2(SMEM_BYTES + 1),
  localparam int TH_W  = $clog2(MAX_THREADS + 1),
  localparam int BK_W  = $clog2(MAX_BLOCKS + 1),
  localparam int WP_W  = $clog2(MAX_BLOCK_THREADS / WARP_SIZE + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  admit_strobe_t       strobe,
  input  logic [ID_W-1:0]     reqId,
  input  logic [RT_W-1:0]     reqThreads,
  input  logic [SM_W-1:0]     reqSmem,
  input  logic [ID_W-1:0]     relId,
  output logic                reqIllegal,
  output logic                reqFits,
  output logic                relHit,
  output logic [WP_W-1:0]     admitWarps,
  output logic [BK_W-1:0]     residentBlocks,
  output logic [TH_W-1:0]     residentThreads,
  output logic [SM_W-1:0]     smemUsed
);

  localparam int IDX_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1;

  // Slot table: one entry per possible resident block.
  logic [MAX_BLOCKS-1:0] slotValid;
  logic [ID_W-1:0]       slotId      [MAX_BLOCKS];
  logic [RT_W-1:0]       slotThreads [MAX_BLOCKS];
  logic [SM_W-1:0]       slotSmem    [MAX_BLOCKS];

  logic [IDX_W-1:0] freeIdx;
  logic             anyFree;
  logic [IDX_W-1:0] relIdx;
  logic             dupHit;

  // Lowest free slot, and lookup of the two identifiers.
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    relIdx  = '0;
    relHit  = 1'b0;
    dupHit  = 1'b0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--) begin
      if (!slotValid[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
    for (int i = 0; i < MAX_BLOCKS; i++) begin
      if (slotValid[i] && slotId[i] == relId) begin
        relIdx = IDX_W'(i);
        relHit = 1'b1;
      end
      if (slotValid[i] && slotId[i] == reqId) begin
        dupHit = 1'b1;
      end
    end
  end

  // Request classification against the totals held before this edge.
  logic threadsOk;
  logic smemOk;

  always_comb begin
    reqIllegal = (reqThreads == '0)
              || (int'(reqThreads) > MAX_BLOCK_THREADS)
              || (int'(reqSmem) > SMEM_BYTES)
              || dupHit;
    threadsOk  = (int'(residentThreads) + int'(reqThreads)) <= MAX_THREADS;
    smemOk     = (int'(smemUsed) + int'(reqSmem)) <= SMEM_BYTES;
    reqFits    = anyFree && threadsOk && smemOk;
  end

  // Per-slot storage.
  for (genvar g = 0; g < MAX_BLOCKS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[g]   <= 1'b0;
        slotId[g]      <= '0;
        slotThreads[g] <= '0;
        slotSmem[g]    <= '0;
      end else if (strobe.take && freeIdx == IDX_W'(g)) begin
        slotValid[g]   <= 1'b1;
        slotId[g]      <= reqId;
        slotThreads[g] <= reqThreads;
        slotSmem[g]    <= reqSmem;
      end else if (strobe.free && relIdx == IDX_W'(g)) begin
        slotValid[g]   <= 1'b0;
      end
    end
  end

  // Running totals: add on take, subtract on release, both in one step.
  logic [BK_W-1:0] blocksNext;
  logic [TH_W-1:0] threadsNext;
  logic [SM_W-1:0] smemNext;
  logic [TH_W-1:0] addThreads;
  logic [TH_W-1:0] subThreads;
  logic [SM_W-1:0] addSmem;
  logic [SM_W-1:0] subSmem;

  always_comb begin
    addThreads  = strobe.take ? TH_W'(reqThreads) : '0;
    subThreads  = strobe.free ? TH_W'(slotThreads[relIdx]) : '0;
    addSmem     = strobe.take ? reqSmem : '0;
    subSmem     = strobe.free ? slotSmem[relIdx] : '0;
    blocksNext  = residentBlocks + BK_W'(strobe.take) - BK_W'(strobe.free);
    threadsNext = residentThreads + addThreads - subThreads;
    smemNext    = smemUsed + addSmem - subSmem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      residentBlocks  <= '0;
      residentThreads <= '0;
      smemUsed        <= '0;
      admitWarps      <= '0;
    end else begin
      residentBlocks  <= blocksNext;
      residentThreads <= threadsNext;
      smemUsed        <= smemNext;
      if (strobe.take) begin
        admitWarps <= WP_W'((int'(reqThreads) + WARP_SIZE - 1) / WARP_SIZE);
      end
    end
  end

  // Limits are never exceeded.
  p_block_cap_r1: assert property (@(posedge clk) disable iff (!rstN)
    int'(residentBlocks) <= MAX_BLOCKS);

  p_thread_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(residentThreads) <= MAX_THREADS);

  p_smem_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(smemUsed) <= SMEM_BYTES);

  // Dropped illegal request leaves the thread total alone (R4).
  p_drop_no_change_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drop && !strobe.free) |=> residentThreads == $past(residentThreads));

  // Taking a block adds exactly one slot (R5).
  p_take_adds_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.free) |=> residentBlocks == $past(residentBlocks) + 1'b1);

  // A taken block always occupies at least one warp (R6).
  p_warps_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> admitWarps != '0);

  // A release returns one slot (R8).
  p_release_frees_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.free && !strobe.take) |=> residentBlocks == $past(residentBlocks) - 1'b1);

  // Take and release together keep the slot count (R9).
  p_both_keep_slots_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.free) |=> residentBlocks == $past(residentBlocks));

  // A missed release alters nothing (R10).
  p_miss_no_change_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.miss && !strobe.take) |=> smemUsed == $past(smemUsed));

endmodule

// File: rtl/admit_control.sv
module admit_control
  import admit_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          relValid,
  input  logic          reqIllegal,
  input  logic          reqFits,
  input  logic          relHit,
  output logic          reqReady,
  output admit_strobe_t strobe,
  output logic          admitValid,
  output logic          reqError,
  output logic          relError
);

  always_comb begin
    strobe.take = reqValid && !reqIllegal && reqFits;
    strobe.drop = reqValid && reqIllegal;
    strobe.free = relValid && relHit;
    strobe.miss = relValid && !relHit;
    reqReady    = strobe.take || strobe.drop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      admitValid <= 1'b0;
      reqError   <= 1'b0;
      relError   <= 1'b0;
    end else begin
      admitValid <= strobe.take;
      reqError   <= strobe.drop;
      relError   <= strobe.miss;
    end
  end

  // Illegal requests are consumed and flagged next cycle (R4).
  p_illegal_flagged_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIllegal) |=> reqError && !admitValid);

  // A handshake on a legal request yields an admit pulse (R5).
  p_accept_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqIllegal) |=> admitValid && !reqError);

  // A legal request that does not fit is held back (R7).
  p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIllegal && !reqFits) |-> !reqReady);

  // Release of a non-resident block is flagged (R10).
  p_release_miss_r10: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !relHit) |=> relError);

  // No ready without a request (R11).
  p_no_ready_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !reqReady);

endmodule

// File: rtl/block_admission_unit.sv
module block_admission_unit
  import admit_pkg::*;
#(
  parameter int MAX_BLOCKS        = 8,
  parameter int MAX_THREADS       = 768,
  parameter int SMEM_BYTES        = 16384,
  parameter int MAX_BLOCK_THREADS = 512,
  parameter int WARP_SIZE         = 32,
  parameter int ID_W              = 8
) (
  input  logic                                              clk,
  input  logic                                              rstN,
  input  logic                                              reqValid,
  output logic                                              reqReady,
  input  logic [ID_W-1:0]                                   reqId,
  input  logic [$clog2(MAX_BLOCK_THREADS+1)-1:0]            reqThreads,
  input  logic [$clog2(SMEM_BYTES+1)-1:0]                   reqSmem,
  output logic                                              admitValid,
  output logic [$clog2(MAX_BLOCK_THREADS/WARP_SIZE+1)-1:0]  admitWarps,
  output logic                                              reqError,
  input  logic                                              relValid,
  input  logic [ID_W-1:0]                                   relId,
  output logic                                              relError,
  output logic [$clog2(MAX_BLOCKS+1)-1:0]                   residentBlocks,
  output logic [$clog2(MAX_THREADS+1)-1:0]                  residentThreads,
  output logic [$clog2(SMEM_BYTES+1)-1:0]                   smemUsed
);

  admit_strobe_t strobe;
  logic          reqIllegal;
  logic          reqFits;
  logic          relHit;

  admit_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .relValid   (relValid),
    .reqIllegal (reqIllegal),
    .reqFits    (reqFits),
    .relHit     (relHit),
    .reqReady   (reqReady),
    .strobe     (strobe),
    .admitValid (admitValid),
    .reqError   (reqError),
    .relError   (relError)
  );

  admit_datapath #(
    .MAX_BLOCKS        (MAX_BLOCKS),
    .MAX_THREADS       (MAX_THREADS),
    .SMEM_BYTES        (SMEM_BYTES),
    .MAX_BLOCK_THREADS (MAX_BLOCK_THREADS),
    .WARP_SIZE         (WARP_SIZE),
    .ID_W              (ID_W)
  ) u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .reqId           (reqId),
    .reqThreads      (reqThreads),
    .reqSmem         (reqSmem),
    .relId           (relId),
    .reqIllegal      (reqIllegal),
    .reqFits         (reqFits),
    .relHit          (relHit),
    .admitWarps      (admitWarps),
    .residentBlocks  (residentBlocks),
    .residentThreads (residentThreads),
    .smemUsed        (smemUsed)
  );

endmodule

// File: tb/tb_block_admission_unit.sv
`timescale 1ns/1ps
module tb_block_admission_unit;

  localparam int K_ACC = 0;  // legal, fits
  localparam int K_WAIT = 1; // legal, does not fit
  localparam int K_ILL = 2;  // illegal, dropped
  localparam int K_REL = 3;  // release of a resident block
  localparam int K_MISS = 4; // release of a non-resident block

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  id;
    logic [9:0]  thr;
    logic [14:0] smem;
    logic [4:0]  warps;
    logic [3:0]  eb;
    logic [9:0]  et;
    logic [14:0] es;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd1,  10'd256, 15'd2048,  5'd8,  4'd1, 10'd256, 15'd2048},
    '{3'd0, 8'd2,  10'd100, 15'd0,     5'd4,  4'd2, 10'd356, 15'd2048},
    '{3'd2, 8'd3,  10'd0,   15'd0,     5'd0,  4'd2, 10'd356, 15'd2048},
    '{3'd2, 8'd4,  10'd513, 15'd0,     5'd0,  4'd2, 10'd356, 15'd2048},
    '{3'd2, 8'd5,  10'd32,  15'd16385, 5'd0,  4'd2, 10'd356, 15'd2048},
    '{3'd2, 8'd1,  10'd32,  15'd0,     5'd0,  4'd2, 10'd356, 15'd2048},
    '{3'd1, 8'd6,  10'd512, 15'd0,     5'd0,  4'd2, 10'd356, 15'd2048},
    '{3'd0, 8'd7,  10'd412, 15'd0,     5'd13, 4'd3, 10'd768, 15'd2048},
    '{3'd1, 8'd8,  10'd1,   15'd0,     5'd0,  4'd3, 10'd768, 15'd2048},
    '{3'd3, 8'd2,  10'd0,   15'd0,     5'd0,  4'd2, 10'd668, 15'd2048},
    '{3'd4, 8'd9,  10'd0,   15'd0,     5'd0,  4'd2, 10'd668, 15'd2048},
    '{3'd0, 8'd8,  10'd1,   15'd14336, 5'd1,  4'd3, 10'd669, 15'd16384},
    '{3'd1, 8'd10, 10'd1,   15'd1,     5'd0,  4'd3, 10'd669, 15'd16384},
    '{3'd3, 8'd1,  10'd0,   15'd0,     5'd0,  4'd2, 10'd413, 15'd14336},
    '{3'd3, 8'd7,  10'd0,   15'd0,     5'd0,  4'd1, 10'd1,   15'd14336},
    '{3'd3, 8'd8,  10'd0,   15'd0,     5'd0,  4'd0, 10'd0,   15'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqId = '0;
  logic [9:0]  reqThreads = '0;
  logic [14:0] reqSmem = '0;
  logic        admitValid;
  logic [4:0]  admitWarps;
  logic        reqError;
  logic        relValid = 1'b0;
  logic [7:0]  relId = '0;
  logic        relError;
  logic [3:0]  residentBlocks;
  logic [9:0]  residentThreads;
  logic [14:0] smemUsed;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  block_admission_unit dut (
    .clk (clk), .rstN (rstN),
    .reqValid (reqValid), .reqReady (reqReady), .reqId (reqId),
    .reqThreads (reqThreads), .reqSmem (reqSmem),
    .admitValid (admitValid), .admitWarps (admitWarps), .reqError (reqError),
    .relValid (relValid), .relId (relId), .relError (relError),
    .residentBlocks (residentBlocks), .residentThreads (residentThreads),
    .smemUsed (smemUsed)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkTotals(string tag, int eb, int et, int es);
    chk({tag, " R1 blocks"}, residentBlocks, eb);
    chk({tag, " R2 threads"}, residentThreads, et);
    chk({tag, " R3 smem"}, smemUsed, es);
  endtask

  task automatic doReq(string tag, int id, int thr, int smem, int kind, int warps);
    @(negedge clk);
    reqValid = 1'b1; reqId = 8'(id); reqThreads = 10'(thr); reqSmem = 15'(smem);
    #1;
    chk({tag, " ready"}, reqReady, (kind != K_WAIT) ? 1 : 0);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk({tag, " admitValid"}, admitValid, (kind == K_ACC) ? 1 : 0);
    chk({tag, " reqError"}, reqError, (kind == K_ILL) ? 1 : 0);
    if (kind == K_ACC) chk({tag, " R6 warps"}, admitWarps, warps);
  endtask

  task automatic doRel(string tag, int id, int hit);
    @(negedge clk);
    relValid = 1'b1; relId = 8'(id);
    @(negedge clk);
    relValid = 1'b0;
    #1;
    chk({tag, " relError"}, relError, hit ? 0 : 1);
  endtask

  initial begin
    #(150000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R11: reset state
    chkTotals("R11 in reset", 0, 0, 0);
    chk("R11 admitValid", admitValid, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chkTotals("R11 after reset", 0, 0, 0);
    chk("R11 ready idle", reqReady, 0);
    chk("R11 errors low", reqError | relError, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      case (int'(VECS[v].kind))
        K_ACC:  tag = "R5 accept";
        K_WAIT: tag = "R7 wait";
        K_ILL:  tag = "R4 illegal";
        K_REL:  tag = "R8 release";
        default: tag = "R10 miss";
      endcase
      if (VECS[v].kind >= 3'd3)
        doRel(tag, VECS[v].id, (VECS[v].kind == 3'd3) ? 1 : 0);
      else
        doReq(tag, VECS[v].id, VECS[v].thr, VECS[v].smem, VECS[v].kind, VECS[v].warps);
      chkTotals(tag, VECS[v].eb, VECS[v].et, VECS[v].es);
    end

    // R1: eight small blocks fill every slot and the whole pool
    for (int k = 0; k < 8; k++) doReq("R1 fill", 20 + k, 64, 2048, K_ACC, 2);
    chkTotals("R1 full", 8, 512, 16384);
    doReq("R1 slot limit", 28, 64, 0, K_WAIT, 0);
    chkTotals("R1 unchanged", 8, 512, 16384);
    doRel("R8 free one", 20, 1);
    chkTotals("R8 freed", 7, 448, 14336);

    // R9: take and release on the same edge
    @(negedge clk);
    reqValid = 1'b1; reqId = 8'd30; reqThreads = 10'd128; reqSmem = 15'd2048;
    relValid = 1'b1; relId = 8'd21;
    #1;
    chk("R9 ready", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0; relValid = 1'b0;
    #1;
    chk("R9 admitValid", admitValid, 1);
    chk("R9 relError", relError, 0);
    chkTotals("R9 both", 7, 512, 14336);

    // R7: held request taken right after a release makes room
    @(negedge clk);
    reqValid = 1'b1; reqId = 8'd31; reqThreads = 10'd320; reqSmem = 15'd0;
    #1;
    chk("R7 held 0", reqReady, 0);
    for (int c = 1; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R7 held", reqReady, 0);
    end
    chkTotals("R7 held totals", 7, 512, 14336);
    @(negedge clk);
    relValid = 1'b1; relId = 8'd22;
    #1;
    chk("R7 ready before release", reqReady, 0);
    @(negedge clk);
    relValid = 1'b0;
    #1;
    chk("R7 ready after release", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk("R7 admitValid", admitValid, 1);
    chk("R6 warps 320", admitWarps, 10);
    chkTotals("R7 taken", 7, 768, 12288);

    // R11: reset clears everything mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chkTotals("R11 mid reset", 0, 0, 0);
    @(negedge clk);
    rstN = 1'b1;
    doReq("R5 after reset", 22, 64, 0, K_ACC, 2);
    chkTotals("R5 after reset", 1, 64, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule